// File: doc/BRIEF.md
# SMBus Bus Condition Monitor

This block watches the two wires of an SMBus slave port and turns their long-term levels into four flags for the slave logic next to it. The raw clock and data lines are brought into the system clock domain, cleaned of short spikes, and then timed by free-running counters. A clock held low for too long produces an abort pulse. A clock held high for too long while the slave says a transaction is open produces the same pulse. Both wires held low for a very long stretch put the bus into an off state. A shorter, software-chosen stretch of both wires low asks the analog front end to run its current-offset calibration.

The slave logic feeds the monitor a transaction-active flag and a calibration delay, and it consumes the flags. When the bus leaves the off state, the available flag returns after a short fixed settling time, well inside one millisecond. All time limits are parameters counted in system clock cycles. The defaults assume a 1 MHz system clock: a 30 ms clock-low limit, a 50 us clock-high limit, a 2 s bus-off limit and a 0.5 ms release delay.

Top module: `smbus_bus_monitor`

## Requirements
- R1: Each line passes a two-flop synchronizer and a filter, so a change on a raw line reaches the timers 2+FILT_LEN cycles after it is first sampled. A raw pulse lasting fewer than FILT_LEN samples is discarded and does not restart any timer.
- R2: When the filtered clock has been low for TIMEOUT_CYC cycles, `abort` is high for exactly one cycle. This happens FILT_LEN+TIMEOUT_CYC+3 cycles after the raw clock falls. The timer saturates, so a longer low period gives no second pulse.
- R3: When `xferActive` is high and the filtered clock has been high for IDLE_CYC cycles, `abort` pulses for one cycle, FILT_LEN+IDLE_CYC+3 cycles after the raw clock rises. With `xferActive` low, a long clock-high gives no pulse.
- R4: When both filtered lines have been low together for OFF_CYC cycles, `busOff` rises and `busAvail` falls in the same cycle. This happens FILT_LEN+OFF_CYC+3 cycles after both raw lines fall.
- R5: `busOff` clears FILT_LEN+3 cycles after either raw line goes high. `busAvail` stays low while `busOff` is high, and it returns FILT_LEN+AVAIL_CYC+4 cycles after the raw release.
- R6: `calReq` rises FILT_LEN+calDelay+3 cycles after both raw lines go low. It falls FILT_LEN+4 cycles after either raw line goes high. A `calDelay` of zero keeps `calReq` low.
- R7: After reset, `abort`, `busOff` and `calReq` are low and `busAvail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Raw SMBus clock line level |
| sdaIn | input | 1 | Raw SMBus data line level |
| xferActive | input | 1 | High while the slave has a transaction open |
| calDelay | input | CAL_W | Both-lines-low cycles before a calibration request; zero disables |
| abort | output | 1 | One-cycle pulse: clock-low timeout or clock-high idle during a transaction |
| busOff | output | 1 | Bus is in the off state |
| busAvail | output | 1 | Bus is usable again |
| calReq | output | 1 | Offset calibration request, held while the condition lasts |

## Verification
Every result is registered after a fixed chain of flops. The chain is two synchronizer flops, FILT_LEN filter samples, the timer itself and one output register. Each flag therefore has an exact cycle count from the bench's drive, as stated in the requirements. The bench drives the lines on a falling clock edge and then counts rising edges. It samples the flags on each following falling edge and records the first cycle at which each flag rises or falls. It compares that index with the requirement's formula, so a change one cycle early or one cycle late is reported. Counting how many cycles `abort` stays high checks the single-pulse and saturation rules.

// File: rtl/smbus_mon_pkg.sv
package smbus_mon_pkg;

  // Strobes from control to the datapath's release-delay timer.
  typedef struct packed {
    logic availRun;   // advance the release timer
    logic availClr;   // hold the release timer at zero
  } ctlStrb_t;

endpackage

// File: rtl/smbus_mon_dp.sv
module smbus_mon_dp
  import smbus_mon_pkg::*;
#(
  parameter int FILT_LEN    = 3,
  parameter int TIMEOUT_CYC = 30000,
  parameter int IDLE_CYC    = 50,
  parameter int AVAIL_CYC   = 500,
  parameter int LOW_W       = 15,
  parameter int HIGH_W      = 6,
  parameter int BOTH_W      = 24,
  parameter int AV_W        = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRaw,
  input  logic              sdaRaw,
  input  ctlStrb_t          strb,
  output logic              sclF,
  output logic              sdaF,
  output logic [LOW_W-1:0]  lowCnt,
  output logic [HIGH_W-1:0] highCnt,
  output logic [BOTH_W-1:0] bothCnt,
  output logic [AV_W-1:0]   availCnt
);

  localparam int FC_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [FC_W-1:0]   FC_LAST = FC_W'(FILT_LEN - 1);
  localparam logic [LOW_W-1:0]  LOW_MAX = LOW_W'(TIMEOUT_CYC);
  localparam logic [HIGH_W-1:0] HIGH_MAX = HIGH_W'(IDLE_CYC);
  localparam logic [AV_W-1:0]   AV_MAX = AV_W'(AVAIL_CYC);

  logic [1:0] rawV;
  logic [1:0] filtV;

  assign rawV = {sdaRaw, sclRaw};

  // One synchronizer plus run-length filter per line.
  for (genvar g = 0; g < 2; g++) begin : gLine
    logic syncA, syncB, filtQ;
    logic [FC_W-1:0] runCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA  <= 1'b1;
        syncB  <= 1'b1;
        filtQ  <= 1'b1;
        runCnt <= '0;
      end else begin
        syncA <= rawV[g];
        syncB <= syncA;
        if (syncB == filtQ) begin
          runCnt <= '0;
        end else if (runCnt == FC_LAST) begin
          filtQ  <= syncB;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end

    assign filtV[g] = filtQ;
  end

  assign sclF = filtV[0];
  assign sdaF = filtV[1];

  // Level timers: each restarts on the edge that ends its level and saturates.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= '0;
      highCnt  <= '0;
      bothCnt  <= '0;
      availCnt <= '0;
    end else begin
      if (sclF)                   lowCnt <= '0;
      else if (lowCnt != LOW_MAX) lowCnt <= lowCnt + 1'b1;

      if (!sclF)                    highCnt <= '0;
      else if (highCnt != HIGH_MAX) highCnt <= highCnt + 1'b1;

      if (sclF || sdaF)       bothCnt <= '0;
      else if (bothCnt != '1) bothCnt <= bothCnt + 1'b1;

      if (strb.availClr)                             availCnt <= '0;
      else if (strb.availRun && availCnt != AV_MAX)  availCnt <= availCnt + 1'b1;
    end
  end

endmodule

// File: rtl/smbus_mon_ctl.sv
module smbus_mon_ctl
  import smbus_mon_pkg::*;
#(
  parameter int TIMEOUT_CYC = 30000,
  parameter int IDLE_CYC    = 50,
  parameter int OFF_CYC     = 2000000,
  parameter int AVAIL_CYC   = 500,
  parameter int CAL_W       = 24,
  parameter int LOW_W       = 15,
  parameter int HIGH_W      = 6,
  parameter int BOTH_W      = 24,
  parameter int AV_W        = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [LOW_W-1:0]  lowCnt,
  input  logic [HIGH_W-1:0] highCnt,
  input  logic [BOTH_W-1:0] bothCnt,
  input  logic [AV_W-1:0]   availCnt,
  input  logic              xferActive,
  input  logic [CAL_W-1:0]  calDelay,
  output ctlStrb_t          strb,
  output logic              abort,
  output logic              busOff,
  output logic              busAvail,
  output logic              calReq
);

  logic lowHit, idleHit, offHit, anyHigh, availDone, calHit;
  logic lowHitQ, idleHitQ, availPend;
  logic [BOTH_W-1:0] calLimit;

  assign calLimit  = BOTH_W'(calDelay);
  assign lowHit    = (lowCnt == LOW_W'(TIMEOUT_CYC));
  assign idleHit   = xferActive && (highCnt == HIGH_W'(IDLE_CYC));
  assign offHit    = (bothCnt >= BOTH_W'(OFF_CYC));
  assign anyHigh   = sclF || sdaF;
  assign availDone = (availCnt == AV_W'(AVAIL_CYC));
  assign calHit    = (calDelay != '0) && (bothCnt >= calLimit);

  assign strb.availRun = availPend;
  assign strb.availClr = !availPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowHitQ   <= 1'b0;
      idleHitQ  <= 1'b0;
      abort     <= 1'b0;
      busOff    <= 1'b0;
      busAvail  <= 1'b1;
      availPend <= 1'b0;
      calReq    <= 1'b0;
    end else begin
      lowHitQ  <= lowHit;
      idleHitQ <= idleHit;
      abort    <= (lowHit && !lowHitQ) || (idleHit && !idleHitQ);
      calReq   <= calHit;

      if (!busOff && offHit) begin
        busOff    <= 1'b1;
        busAvail  <= 1'b0;
        availPend <= 1'b0;
      end else if (busOff && anyHigh) begin
        busOff    <= 1'b0;
        availPend <= 1'b1;
      end else if (availPend && availDone) begin
        availPend <= 1'b0;
        busAvail  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/smbus_bus_monitor.sv
module smbus_bus_monitor
  import smbus_mon_pkg::*;
#(
  parameter int FILT_LEN    = 3,
  parameter int TIMEOUT_CYC = 30000,
  parameter int IDLE_CYC    = 50,
  parameter int OFF_CYC     = 2000000,
  parameter int AVAIL_CYC   = 500,
  parameter int CAL_W       = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             xferActive,
  input  logic [CAL_W-1:0] calDelay,
  output logic             abort,
  output logic             busOff,
  output logic             busAvail,
  output logic             calReq
);

  localparam int LOW_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int HIGH_W = $clog2(IDLE_CYC + 1);
  localparam int OFF_W  = $clog2(OFF_CYC + 1);
  localparam int BOTH_W = (OFF_W > CAL_W) ? OFF_W : CAL_W;
  localparam int AV_W   = (AVAIL_CYC < 1) ? 1 : $clog2(AVAIL_CYC + 1);

  ctlStrb_t          strb;
  logic              sclF, sdaF;
  logic [LOW_W-1:0]  lowCnt;
  logic [HIGH_W-1:0] highCnt;
  logic [BOTH_W-1:0] bothCnt;
  logic [AV_W-1:0]   availCnt;

  smbus_mon_dp #(
    .FILT_LEN(FILT_LEN), .TIMEOUT_CYC(TIMEOUT_CYC), .IDLE_CYC(IDLE_CYC),
    .AVAIL_CYC(AVAIL_CYC), .LOW_W(LOW_W), .HIGH_W(HIGH_W),
    .BOTH_W(BOTH_W), .AV_W(AV_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn), .strb(strb),
    .sclF(sclF), .sdaF(sdaF), .lowCnt(lowCnt), .highCnt(highCnt),
    .bothCnt(bothCnt), .availCnt(availCnt)
  );

  smbus_mon_ctl #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .IDLE_CYC(IDLE_CYC), .OFF_CYC(OFF_CYC),
    .AVAIL_CYC(AVAIL_CYC), .CAL_W(CAL_W), .LOW_W(LOW_W), .HIGH_W(HIGH_W),
    .BOTH_W(BOTH_W), .AV_W(AV_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .lowCnt(lowCnt),
    .highCnt(highCnt), .bothCnt(bothCnt), .availCnt(availCnt),
    .xferActive(xferActive), .calDelay(calDelay), .strb(strb),
    .abort(abort), .busOff(busOff), .busAvail(busAvail), .calReq(calReq)
  );

endmodule

// File: rtl/smbus_mon_chk.sv
module smbus_mon_chk #(
  parameter int CAL_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclF,
  input logic             sdaF,
  input logic [CAL_W-1:0] calDelay,
  input logic             abort,
  input logic             busOff,
  input logic             busAvail,
  input logic             calReq
);

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> !abort);  // R2

  AST_OFF_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOff) |-> $past(!sclF && !sdaF));  // R4

  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && (sclF || sdaF)) |=> !busOff);  // R5

  AST_AVAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    busOff |-> !busAvail);  // R5

  AST_CAL_ZERO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (calDelay == '0) |=> !calReq);  // R6

endmodule

bind smbus_bus_monitor smbus_mon_chk #(.CAL_W(CAL_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .calDelay(calDelay),
  .abort(abort), .busOff(busOff), .busAvail(busAvail), .calReq(calReq)
);

// File: tb/smbus_bus_monitor_tb.sv
module smbus_bus_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FILT  = 3;
  localparam int TOUT  = 40;
  localparam int IDLE  = 20;
  localparam int OFF   = 200;
  localparam int AVAIL = 30;
  localparam int CALW  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic active = 1'b0;
  logic [CALW-1:0] calDly = '0;
  logic abort, busOff, busAvail, calReq;

  int nChecks = 0;
  int nFails = 0;
  int firstHi [4];
  int firstLo [4];
  int hiCnt [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  smbus_bus_monitor #(
    .FILT_LEN(FILT), .TIMEOUT_CYC(TOUT), .IDLE_CYC(IDLE), .OFF_CYC(OFF),
    .AVAIL_CYC(AVAIL), .CAL_W(CALW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaDrv),
    .xferActive(active), .calDelay(calDly), .abort(abort), .busOff(busOff),
    .busAvail(busAvail), .calReq(calReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs maxCyc cycles after a drive made at a falling edge; index i means
  // "sampled after the i-th rising edge". Optional clock glitch injection.
  task automatic observe(input int maxCyc, input int glAt, input int glLen);
    logic [3:0] obs;
    for (int k = 0; k < 4; k++) begin
      firstHi[k] = -1; firstLo[k] = -1; hiCnt[k] = 0;
    end
    for (int i = 1; i <= maxCyc; i++) begin
      @(posedge clk);
      @(negedge clk);
      obs = {calReq, busAvail, busOff, abort};
      for (int k = 0; k < 4; k++) begin
        if (obs[k]) begin
          hiCnt[k]++;
          if (firstHi[k] < 0) firstHi[k] = i;
        end else if (firstLo[k] < 0) begin
          firstLo[k] = i;
        end
      end
      if (i == glAt) sclDrv = 1'b0;
      if (i == glAt + glLen) sclDrv = 1'b1;
    end
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(abort == 1'b0, "R7 abort", int'(abort), 0);
    check(busOff == 1'b0, "R7 busOff", int'(busOff), 0);
    check(busAvail == 1'b1, "R7 busAvail", int'(busAvail), 1);
    check(calReq == 1'b0, "R7 calReq", int'(calReq), 0);
  endtask

  task automatic tTimeout();
    sclDrv = 1'b0;
    observe(TOUT + 40, -1, 0);
    check(firstHi[0] == FILT + TOUT + 3, "R2 timeout cycle", firstHi[0], FILT + TOUT + 3);
    check(hiCnt[0] == 1, "R2 single pulse, saturated", hiCnt[0], 1);
    sclDrv = 1'b1;
    observe(10, -1, 0);
  endtask

  task automatic lowThenRise();
    sclDrv = 1'b0;
    observe(6, -1, 0);
    sclDrv = 1'b1;
  endtask

  task automatic tIdle();
    active = 1'b1;
    lowThenRise();
    observe(IDLE + 20, -1, 0);
    check(firstHi[0] == FILT + IDLE + 3, "R3 idle abort cycle", firstHi[0], FILT + IDLE + 3);
    check(hiCnt[0] == 1, "R3 idle abort pulses", hiCnt[0], 1);
    active = 1'b0;
  endtask

  task automatic tIdleGlitch();
    active = 1'b1;
    lowThenRise();
    observe(IDLE + 20, 5, FILT - 1);
    check(firstHi[0] == FILT + IDLE + 3, "R1 short pulse ignored", firstHi[0], FILT + IDLE + 3);
    active = 1'b0;
  endtask

  task automatic tIdleInactive();
    active = 1'b0;
    lowThenRise();
    observe(IDLE + 40, -1, 0);
    check(hiCnt[0] == 0, "R3 no abort when inactive", hiCnt[0], 0);
  endtask

  task automatic tBusOff();
    sclDrv = 1'b0;
    sdaDrv = 1'b0;
    observe(OFF + 10, -1, 0);
    check(firstHi[1] == FILT + OFF + 3, "R4 busOff rise cycle", firstHi[1], FILT + OFF + 3);
    check(firstLo[2] == FILT + OFF + 3, "R4 busAvail fall cycle", firstLo[2], FILT + OFF + 3);
    sdaDrv = 1'b1;
    observe(AVAIL + 20, -1, 0);
    check(firstLo[1] == FILT + 3, "R5 busOff clear cycle", firstLo[1], FILT + 3);
    check(firstHi[2] == FILT + AVAIL + 4, "R5 busAvail return cycle", firstHi[2], FILT + AVAIL + 4);
    check(hiCnt[0] == 0, "R2 no repeat abort while low", hiCnt[0], 0);
    sclDrv = 1'b1;
    observe(10, -1, 0);
  endtask

  task automatic tCal();
    calDly = CALW'(50);
    sclDrv = 1'b0;
    sdaDrv = 1'b0;
    observe(80, -1, 0);
    check(firstHi[3] == FILT + 50 + 3, "R6 calReq rise cycle", firstHi[3], FILT + 53);
    sclDrv = 1'b1;
    observe(20, -1, 0);
    check(firstLo[3] == FILT + 4, "R6 calReq fall cycle", firstLo[3], FILT + 4);
    sdaDrv = 1'b1;
    observe(10, -1, 0);
  endtask

  task automatic tCalDisabled();
    calDly = '0;
    sclDrv = 1'b0;
    sdaDrv = 1'b0;
    observe(120, -1, 0);
    check(hiCnt[3] == 0, "R6 zero delay disables", hiCnt[3], 0);
    check(hiCnt[1] == 0, "R4 no busOff before limit", hiCnt[1], 0);
    sclDrv = 1'b1;
    sdaDrv = 1'b1;
    observe(10, -1, 0);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tTimeout();
    tIdle();
    tIdleGlitch();
    tIdleInactive();
    tBusOff();
    tCal();
    tCalDisabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule